// File: doc/BRIEF.md
# Oscillator Edge Timestamp Capture

This block watches a square wave that arrives from an oscillator with no relation to the system clock. It records the system-clock cycle at which the edges of that wave occur. A free-running counter steps down by one on every clock. Each qualifying edge pushes the counter value at that moment, with a polarity tag, into a small output queue. The queue hands words on over a valid/ready handshake. A downstream consumer takes the difference of two timestamps to get the length of one or more periods, resolved to a single clock cycle.

The input first passes through a two-flop synchronizer, so every timestamp carries the same fixed delay. A two-bit mode selects which edges count: rising, falling or both. If the queue is full when an edge arrives, that edge is lost and a sticky flag records the loss until it is cleared. A built-in span unit keeps the most recent timestamps. Once enough edges have been seen, it reports the cycle count covered by a programmable number N of periods on every new edge.

Top module: `edge_ts_capture`

## Requirements
- R1: The timestamp counter decrements by one every clock cycle and wraps modulo 2^32. The difference (earlier minus later, modulo 2^32) of two queued timestamps equals the number of clock cycles between the two corresponding input transitions.
- R2: `edgeMode` selects the edges that are captured. 2'b01 captures rising edges only, 2'b10 falling edges only, 2'b11 both, and 2'b00 none, so nothing is queued.
- R3: An edge that arrives while the queue holds 16 words is dropped and sets `overflow`. The drop happens even if a word is read in the same cycle. `overflow` stays set until `ovfClear` is asserted, and a new drop in the same cycle takes precedence over the clear.
- R4: `tsRising` is 1 for a word produced by a rising edge and 0 for a falling edge. In both-edge mode the tags of consecutive words alternate.
- R5: The queue is first-in first-out and holds 16 words. `tsValid` is high whenever it is non-empty, and a word leaves only on a cycle with `tsValid` and `tsReady` both high. While `tsReady` is low, `tsData` and `tsRising` hold steady.
- R6: With `spanCount` = N (valid range 1 to 16; 0 acts as 1, larger values act as 16), `spanValid` pulses for one cycle on each captured edge from the (N+1)-th captured edge onward. At each pulse, `spanCycles` holds the timestamp of the edge N captures earlier minus the current timestamp, modulo 2^32. Captured edges count for the span even when the queue drops them.
- R7: While `rstN` is low, the queue is empty, `tsValid`, `overflow` and `spanValid` are 0, and the edge history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sigIn | input | 1 | Asynchronous oscillator square wave |
| edgeMode | input | 2 | Edge select: 01 rising, 10 falling, 11 both, 00 off |
| spanCount | input | 5 | Number of periods N covered by the span output |
| ovfClear | input | 1 | Clears the sticky overflow flag |
| tsReady | input | 1 | Consumer accepts the word at the queue head |
| tsValid | output | 1 | Queue head holds a word |
| tsData | output | 32 | Timestamp at the queue head |
| tsRising | output | 1 | Polarity tag of the queue head word |
| overflow | output | 1 | Sticky flag: at least one edge was dropped |
| spanValid | output | 1 | One-cycle pulse: span result updated |
| spanCycles | output | 32 | Clock cycles covered by the last N periods |

## Verification
A wrong counter step or a mis-registered edge shows up as soon as two consecutive queued words are compared. Their difference then no longer matches the known spacing of the driven transitions. A broken queue pointer shows up on the first drain as missing, repeated or reordered words. A wrong polarity decode shows up as the wrong word count or wrong tags for the selected mode. A stale entry in the edge history corrupts `spanCycles` on the first pulse after the (N+1)-th edge. Sweeping N over the full range checks every position in the history.

// File: rtl/edge_ts_pkg.sv
package edge_ts_pkg;
  localparam int TS_W = 32;

  typedef struct packed {
    logic capture;   // a qualifying edge was seen this cycle
    logic rising;    // polarity of that edge
  } edge_strobe_t;
endpackage

// File: rtl/edge_ts_ctrl.sv
module edge_ts_ctrl
  import edge_ts_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sigIn,
  input  logic [1:0]   edgeMode,
  output edge_strobe_t strobe
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   lastLevel;
  logic                   nowLevel;

  assign nowLevel = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain <= '0;
      lastLevel <= 1'b0;
    end else begin
      syncChain <= {syncChain[SYNC_STAGES-2:0], sigIn};
      lastLevel <= nowLevel;
    end
  end

  logic riseSeen, fallSeen;
  always_comb begin
    riseSeen = nowLevel & ~lastLevel;
    fallSeen = ~nowLevel & lastLevel;
    strobe.capture = (riseSeen & edgeMode[0]) | (fallSeen & edgeMode[1]);
    strobe.rising  = riseSeen;
  end
endmodule

// File: rtl/edge_ts_datapath.sv
module edge_ts_datapath
  import edge_ts_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_SPAN   = 16,
  localparam int PTR_W     = $clog2(FIFO_DEPTH),
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int SPAN_W    = $clog2(MAX_SPAN + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  edge_strobe_t      strobe,
  input  logic [SPAN_W-1:0] spanCount,
  input  logic              ovfClear,
  input  logic              tsReady,
  output logic              tsValid,
  output logic [TS_W-1:0]   tsData,
  output logic              tsRising,
  output logic              overflow,
  output logic              spanValid,
  output logic [TS_W-1:0]   spanCycles
);
  // free-running down-counter
  logic [TS_W-1:0] tick;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tick <= '0;
    else       tick <= tick - 1'b1;
  end

  // output queue
  logic [TS_W:0]    store [FIFO_DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] fill;
  logic             isFull, doPush, doPop;

  assign isFull  = (fill == CNT_W'(FIFO_DEPTH));
  assign tsValid = (fill != '0);
  assign doPush  = strobe.capture & ~isFull;
  assign doPop   = tsValid & tsReady;
  assign {tsRising, tsData} = store[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= {strobe.rising, tick};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      fill     <= '0;
      overflow <= 1'b0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      fill <= fill + CNT_W'(doPush) - CNT_W'(doPop);
      if (strobe.capture & isFull) overflow <= 1'b1;
      else if (ovfClear)           overflow <= 1'b0;
    end
  end

  // span unit: history of the last MAX_SPAN captured timestamps
  logic [TS_W-1:0]   history [MAX_SPAN];
  logic [SPAN_W-1:0] seen;
  logic [SPAN_W-1:0] spanEff;

  always_comb begin
    if (spanCount == '0)                       spanEff = SPAN_W'(1);
    else if (spanCount > SPAN_W'(MAX_SPAN))    spanEff = SPAN_W'(MAX_SPAN);
    else                                       spanEff = spanCount;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) history[0] <= '0;
    else if (strobe.capture) history[0] <= tick;
  end

  for (genvar i = 1; i < MAX_SPAN; i++) begin : g_hist
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) history[i] <= '0;
      else if (strobe.capture) history[i] <= history[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen       <= '0;
      spanValid  <= 1'b0;
      spanCycles <= '0;
    end else begin
      spanValid <= 1'b0;
      if (strobe.capture) begin
        if (seen != SPAN_W'(MAX_SPAN)) seen <= seen + 1'b1;
        if (seen >= spanEff) begin
          spanValid  <= 1'b1;
          spanCycles <= history[spanEff - 1'b1] - tick;
        end
      end
    end
  end
endmodule

// File: rtl/edge_ts_capture.sv
module edge_ts_capture
  import edge_ts_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int MAX_SPAN   = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sigIn,
  input  logic [1:0]  edgeMode,
  input  logic [4:0]  spanCount,
  input  logic        ovfClear,
  input  logic        tsReady,
  output logic        tsValid,
  output logic [31:0] tsData,
  output logic        tsRising,
  output logic        overflow,
  output logic        spanValid,
  output logic [31:0] spanCycles
);
  edge_strobe_t strobe;

  edge_ts_ctrl #(.SYNC_STAGES(2)) u_ctrl (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .edgeMode(edgeMode), .strobe(strobe)
  );

  edge_ts_datapath #(.FIFO_DEPTH(FIFO_DEPTH), .MAX_SPAN(MAX_SPAN)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spanCount(spanCount),
    .ovfClear(ovfClear), .tsReady(tsReady), .tsValid(tsValid), .tsData(tsData),
    .tsRising(tsRising), .overflow(overflow), .spanValid(spanValid),
    .spanCycles(spanCycles)
  );
endmodule

// File: rtl/edge_ts_capture_chk.sv
module edge_ts_capture_chk (
  input logic        clk,
  input logic        rstN,
  input logic        ovfClear,
  input logic        tsReady,
  input logic        tsValid,
  input logic [31:0] tsData,
  input logic        tsRising,
  input logic        overflow,
  input logic        spanValid,
  input logic [31:0] spanCycles
);
  // R3: the flag only falls when a clear was requested
  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow && !ovfClear |=> overflow);

  // R5: head word is held while the consumer stalls
  p_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    tsValid && !tsReady |=> tsValid && $stable(tsData) && $stable(tsRising));

  // R6: a span over at least one period covers at least one cycle
  p_span_nonzero_r6: assert property (@(posedge clk) disable iff (!rstN)
    spanValid |-> spanCycles != 32'd0);

  // R6: span result changes only together with a pulse
  p_span_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    !spanValid |=> spanValid || $stable(spanCycles));

  // R7: reset empties the queue and clears the flags
  p_reset_r7: assert property (@(posedge clk)
    !rstN |=> !tsValid && !overflow && !spanValid);
endmodule

bind edge_ts_capture edge_ts_capture_chk u_chk (
  .clk(clk), .rstN(rstN), .ovfClear(ovfClear), .tsReady(tsReady),
  .tsValid(tsValid), .tsData(tsData), .tsRising(tsRising), .overflow(overflow),
  .spanValid(spanValid), .spanCycles(spanCycles)
);

// File: tb/edge_ts_capture_tb.sv
module edge_ts_capture_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sigIn = 1'b0;
  logic [1:0]  edgeMode = 2'b01;
  logic [4:0]  spanCount = 5'd1;
  logic        ovfClear = 1'b0;
  logic        tsReady = 1'b0;
  logic        tsValid, tsRising, overflow, spanValid;
  logic [31:0] tsData, spanCycles;

  int vectors = 0;
  int errors  = 0;
  logic [31:0] gotTs  [64];
  logic        gotTag [64];
  int          gotN;
  int          spanHits;
  logic [31:0] lastSpan;

  always #10 clk = ~clk;

  edge_ts_capture u_dut (
    .clk(clk), .rstN(rstN), .sigIn(sigIn), .edgeMode(edgeMode),
    .spanCount(spanCount), .ovfClear(ovfClear), .tsReady(tsReady),
    .tsValid(tsValid), .tsData(tsData), .tsRising(tsRising),
    .overflow(overflow), .spanValid(spanValid), .spanCycles(spanCycles)
  );

  always @(negedge clk) begin
    if (spanValid) begin
      spanHits++;
      lastSpan = spanCycles;
    end
  end

  task automatic check(string req, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; sigIn = 1'b0; tsReady = 1'b0; ovfClear = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse(int hi, int lo);
    sigIn = 1'b1;
    repeat (hi) @(negedge clk);
    sigIn = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
    gotN = 0;
    tsReady = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (tsValid && gotN < 64) begin
        gotTs[gotN]  = tsData;
        gotTag[gotN] = tsRising;
        gotN++;
      end
      @(negedge clk);
    end
    tsReady = 1'b0;
  endtask

  task automatic pattern();
    pulse(2, 3); pulse(5, 2); pulse(3, 7); pulse(10, 4);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int riseGap [3] = '{5, 7, 10};
    int fallGap [3] = '{8, 5, 17};
    int spanSet [6] = '{1, 2, 3, 7, 15, 16};

    // R7: reset state
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 tsValid", tsValid, 0);
    check("R7 overflow", overflow, 0);
    check("R7 spanValid", spanValid, 0);
    doReset();

    // R1/R2/R4: rising edges only
    edgeMode = 2'b01;
    pattern();
    drain();
    check("R2 rising count", gotN, 4);
    for (int i = 1; i < 4; i++)
      check("R1 rising gap", gotTs[i-1] - gotTs[i], riseGap[i-1]);
    for (int i = 0; i < 4; i++) check("R4 rising tag", gotTag[i], 1);

    // R1/R2/R4: falling edges only
    doReset();
    edgeMode = 2'b10;
    pattern();
    drain();
    check("R2 falling count", gotN, 4);
    for (int i = 1; i < 4; i++)
      check("R1 falling gap", gotTs[i-1] - gotTs[i], fallGap[i-1]);
    for (int i = 0; i < 4; i++) check("R4 falling tag", gotTag[i], 0);

    // R2/R4: both edges, alternating tags
    doReset();
    edgeMode = 2'b11;
    for (int k = 0; k < 4; k++) pulse(4, 5);
    drain();
    check("R2 both count", gotN, 8);
    for (int i = 0; i < 8; i++) check("R4 both tag", gotTag[i], (i % 2 == 0) ? 1 : 0);
    for (int i = 1; i < 8; i++)
      check("R1 both gap", gotTs[i-1] - gotTs[i], (i % 2 == 1) ? 4 : 5);

    // R2: mode off
    doReset();
    edgeMode = 2'b00;
    pattern();
    drain();
    check("R2 off count", gotN, 0);

    // R3/R5: overflow with 20 edges into 16 slots
    doReset();
    edgeMode = 2'b01;
    for (int k = 0; k < 20; k++) pulse(3, 3);
    repeat (5) @(negedge clk);
    check("R3 overflow set", overflow, 1);
    check("R5 valid while full", tsValid, 1);
    drain();
    check("R5 depth", gotN, 16);
    for (int i = 1; i < 16; i++) check("R5 order", gotTs[i-1] - gotTs[i], 6);
    check("R3 still sticky", overflow, 1);
    ovfClear = 1'b1; @(negedge clk); ovfClear = 1'b0; @(negedge clk);
    check("R3 cleared", overflow, 0);

    // R6: span sweep, period 7 cycles
    foreach (spanSet[j]) begin
      doReset();
      edgeMode = 2'b01;
      spanCount = 5'(spanSet[j]);
      tsReady = 1'b1;
      spanHits = 0;
      lastSpan = '0;
      for (int k = 0; k < spanSet[j] + 4; k++) pulse(3, 4);
      repeat (6) @(negedge clk);
      check("R6 span pulses", spanHits, 4);
      check("R6 span value", lastSpan, 7 * spanSet[j]);
    end

    // R6: span over both-edge captures, N=3, half periods 4 and 5
    doReset();
    edgeMode = 2'b11;
    spanCount = 5'd3;
    tsReady = 1'b1;
    spanHits = 0;
    for (int k = 0; k < 3; k++) pulse(4, 5);
    repeat (6) @(negedge clk);
    check("R6 both pulses", spanHits, 3);
    check("R6 both value", lastSpan, 4 + 5 + 4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule